// File: doc/BRIEF.md
# BFloat16 Lane Maximum/Minimum Unit

This block is one vector lane that returns the larger or the smaller of two BFloat16 values. Zeros and NaNs follow one of two conventions picked by a control pin. With the strict convention, zeros are ordered by sign and a NaN operand yields a NaN: either the quieted operand or the canonical NaN `16'h7FC0`. With the alternate convention, the second operand is returned whenever both operands are zeros or either operand is a NaN. A flag marks any signaling NaN operand on an active lane. A lane whose enable is low returns its first operand unchanged.

Operands come in on a valid/ready stream and results leave on a valid/ready stream, through one register stage. A beat is taken when `in_valid` and `in_ready` are both high. The result is offered on the next cycle. A stalled result (`out_valid` high, `out_ready` low) holds steady and pulls `in_ready` low. The input may then hold or change its beat, because nothing is taken until `in_ready` rises again. The mode pins (`in_sel_min`, `in_alt`, `in_dflt_nan`, `in_lane_en`) travel with the operand beat.

Top module: `bf16_minmax_lane`

## Requirements
- R1: When `in_lane_en` is 0, the result equals `in_a` bit for bit and `out_inv` is 0, whatever the other inputs are.
- R2: A NaN has exponent bits [14:7] all ones and a nonzero mantissa [6:0]. With no NaN operand and not two zeros, `in_sel_min`=0 returns the numerically larger operand and 1 returns the smaller, in sign-magnitude order, infinities included.
- R3: When `in_alt`=0, negative zero (`16'h8000`) counts as less than positive zero (`16'h0000`) for both maximum and minimum.
- R4: When `in_alt`=0 and `in_dflt_nan`=1, any NaN operand gives exactly `16'h7FC0`.
- R5: When `in_alt`=0 and `in_dflt_nan`=0, any NaN operand gives a quieted NaN. Mantissa bit 6 clear means signaling, and quieting sets bit 6. A signaling operand is chosen before a quiet one, and `in_a` is chosen before `in_b` at equal rank.
- R6: When `in_alt`=1 and both operands are zeros of any sign, the result is `in_b`.
- R7: When `in_alt`=1 and either operand is a NaN, the result is `in_b` unchanged, whatever `in_dflt_nan` is.
- R8: On an active lane, `out_inv` is 1 exactly when at least one operand is a signaling NaN, in either convention.
- R9: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted beat is offered on the next cycle. While `out_valid` is high and `out_ready` is low, `out_res` and `out_inv` do not change.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Beat can be taken |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_sel_min | input | 1 | 0 selects maximum, 1 selects minimum |
| in_alt | input | 1 | Alternate zero/NaN convention |
| in_dflt_nan | input | 1 | Canonical NaN output under strict convention |
| in_lane_en | input | 1 | Lane active |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_res | output | 16 | Selected value |
| out_inv | output | 1 | Signaling NaN operand seen |

## Verification
The assertions assume that the consumer may stall at any time, and that `in_a` is driven to known values on every cycle in which a beat is taken. The pass-through check relies on this. The bench drives inputs only between clock edges. It lowers `out_ready` only inside the back-pressure scenario, where it offers a second beat during the stall to show that the beat is not taken. All NaN stimuli use explicit mantissa patterns, so that the quiet/signaling split at bit 6 is exercised on both sides.

// File: rtl/bf16_mm_pkg.sv
package bf16_mm_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned EXP_W  = 8;
  parameter int unsigned MAN_W  = WORD_W - EXP_W - 1;
  localparam int unsigned QUIET_BIT = MAN_W - 1;
  localparam logic [WORD_W-1:0] CANON_NAN = 16'h7FC0;

  typedef struct packed {
    logic              nan;
    logic              sig;
    logic              zero;
    logic [WORD_W-1:0] key;
  } opnd_info_t;
endpackage

// File: rtl/bf16_opnd_class.sv
module bf16_opnd_class
  import bf16_mm_pkg::*;
(
  input  logic [WORD_W-1:0] val,
  output opnd_info_t        info
);
  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;

  assign sgn = val[WORD_W-1];
  assign ex  = val[WORD_W-2 -: EXP_W];
  assign man = val[MAN_W-1:0];

  always_comb begin
    info.nan  = (&ex) && (|man);
    info.sig  = info.nan && !man[QUIET_BIT];
    info.zero = (ex == '0) && (man == '0);
    // flip sign for positives, invert all for negatives: unsigned key order
    info.key  = sgn ? ~val : {1'b1, val[WORD_W-2:0]};
  end
endmodule

// File: rtl/bf16_mm_core.sv
module bf16_mm_core
  import bf16_mm_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sel_min,
  input  logic              alt,
  input  logic              dflt_nan,
  input  logic              lane_en,
  output logic [WORD_W-1:0] res,
  output logic              inv
);
  localparam int unsigned NOPS = 2;
  logic [WORD_W-1:0] ops  [NOPS];
  opnd_info_t        kind [NOPS];

  assign ops[0] = a;
  assign ops[1] = b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    bf16_opnd_class u_cls (.val(ops[i]), .info(kind[i]));
  end

  logic any_nan, a_wins;
  logic [WORD_W-1:0] qa, qb, nan_pick;

  assign any_nan = kind[0].nan | kind[1].nan;
  assign qa = a | (WORD_W'(1) << QUIET_BIT);
  assign qb = b | (WORD_W'(1) << QUIET_BIT);
  assign a_wins = sel_min ? (kind[0].key < kind[1].key)
                          : (kind[0].key > kind[1].key);

  always_comb begin
    if (kind[0].sig)      nan_pick = qa;
    else if (kind[1].sig) nan_pick = qb;
    else if (kind[0].nan) nan_pick = qa;
    else                  nan_pick = qb;
  end

  always_comb begin
    if (!lane_en)                              res = a;
    else if (alt && (any_nan || (kind[0].zero && kind[1].zero))) res = b;
    else if (any_nan)                          res = dflt_nan ? CANON_NAN : nan_pick;
    else                                       res = a_wins ? a : b;
    inv = lane_en && (kind[0].sig || kind[1].sig);
  end

  always_comb begin
    if (lane_en && !alt && dflt_nan && any_nan)
      a_r4_canon: assert (res == CANON_NAN);
    if (lane_en && alt && any_nan)
      a_r7_alt_b: assert (res == b);
    if (lane_en && !alt && !dflt_nan && any_nan)
      a_r5_quiet: assert ((&res[WORD_W-2 -: EXP_W]) && res[QUIET_BIT]);
    if (inv)
      a_r8_inv_src: assert ((&a[WORD_W-2 -: EXP_W]) || (&b[WORD_W-2 -: EXP_W]));
  end
endmodule

// File: rtl/bf16_mm_stage.sv
module bf16_mm_stage #(
  parameter int unsigned PW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
  a_r9_offer: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid && dn_data == $past(up_data));
endmodule

// File: rtl/bf16_minmax_lane.sv
module bf16_minmax_lane
  import bf16_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_sel_min,
  input  logic              in_alt,
  input  logic              in_dflt_nan,
  input  logic              in_lane_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_res,
  output logic              out_inv
);
  localparam int unsigned PW = WORD_W + 1;
  logic [WORD_W-1:0] c_res;
  logic              c_inv;

  bf16_mm_core u_core (
    .a(in_a), .b(in_b), .sel_min(in_sel_min), .alt(in_alt),
    .dflt_nan(in_dflt_nan), .lane_en(in_lane_en), .res(c_res), .inv(c_inv)
  );

  bf16_mm_stage #(.PW(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data({c_inv, c_res}),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data({out_inv, out_res})
  );

  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_lane_en |=> out_res == $past(in_a) && !out_inv);
  a_r6_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_lane_en && in_alt &&
    in_a[WORD_W-2:0] == '0 && in_b[WORD_W-2:0] == '0 |=> out_res == $past(in_b));
endmodule

// File: tb/bf16_minmax_lane_test.sv
module bf16_minmax_lane_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sel_min = 0, in_alt = 0, in_dflt_nan = 0, in_lane_en = 1;
  logic out_ready = 1;
  logic [15:0] in_a = 0, in_b = 0;
  logic in_ready, out_valid, out_inv;
  logic [15:0] out_res;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bf16_minmax_lane uut (.*);

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [15:0] a, logic [15:0] b, logic mn, logic al,
                      logic dn, logic en, logic [15:0] er, logic ei);
    @(negedge clk);
    in_a = a; in_b = b; in_sel_min = mn; in_alt = al; in_dflt_nan = dn;
    in_lane_en = en; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " valid"}, {16'h0, out_valid}, 17'h1);
    chk(tag, {out_inv, out_res}, {ei, er});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 out_valid", {16'h0, out_valid}, 17'h0);
    chk("R10 in_ready", {16'h0, in_ready}, 17'h1);
  endtask

  task automatic t_numeric();
    send("R2 max pos", 16'h3F80, 16'h4000, 0, 0, 0, 1, 16'h4000, 0);
    send("R2 min pos", 16'h3F80, 16'h4000, 1, 0, 0, 1, 16'h3F80, 0);
    send("R2 max mixed", 16'hBF80, 16'h3F00, 0, 1, 0, 1, 16'h3F00, 0);
    send("R2 min neg", 16'hC000, 16'hBF80, 1, 0, 0, 1, 16'hC000, 0);
    send("R2 max inf", 16'h4000, 16'h7F80, 0, 0, 0, 1, 16'h7F80, 0);
    send("R2 min -inf", 16'hFF80, 16'hC000, 1, 1, 0, 1, 16'hFF80, 0);
  endtask

  task automatic t_zero_strict();
    send("R3 max -0,+0", 16'h8000, 16'h0000, 0, 0, 0, 1, 16'h0000, 0);
    send("R3 min +0,-0", 16'h0000, 16'h8000, 1, 0, 0, 1, 16'h8000, 0);
  endtask

  task automatic t_zero_alt();
    send("R6 max -0,+0", 16'h8000, 16'h0000, 0, 1, 0, 1, 16'h0000, 0);
    send("R6 max +0,-0", 16'h0000, 16'h8000, 0, 1, 0, 1, 16'h8000, 0);
    send("R6 min -0,+0", 16'h8000, 16'h0000, 1, 1, 0, 1, 16'h0000, 0);
  endtask

  task automatic t_nan_default();
    send("R4 snan a", 16'h7F81, 16'h3F80, 0, 0, 1, 1, 16'h7FC0, 1);
    send("R4 qnan b", 16'h3F80, 16'h7FC5, 1, 0, 1, 1, 16'h7FC0, 0);
  endtask

  task automatic t_nan_prop();
    send("R5 snan b quieted", 16'h3F80, 16'h7F81, 0, 0, 0, 1, 16'h7FC1, 1);
    send("R5 snan b over qnan a", 16'h7FC2, 16'h7F83, 0, 0, 0, 1, 16'h7FC3, 1);
    send("R5 both quiet a first", 16'h7FC2, 16'h7FC4, 0, 0, 0, 1, 16'h7FC2, 0);
    send("R5 neg snan a", 16'hFF90, 16'h3F80, 1, 0, 0, 1, 16'hFFD0, 1);
  endtask

  task automatic t_nan_alt();
    send("R7 qnan a dn1", 16'h7FC5, 16'h3F80, 0, 1, 1, 1, 16'h3F80, 0);
    send("R7 snan b R8", 16'h3F80, 16'h7F81, 0, 1, 1, 1, 16'h7F81, 1);
    send("R7 snan a dn0 R8", 16'h7F81, 16'h4000, 1, 1, 0, 1, 16'h4000, 1);
  endtask

  task automatic t_inactive();
    send("R1 lane off", 16'h1234, 16'h7F81, 0, 0, 1, 0, 16'h1234, 0);
    send("R1 lane off alt", 16'h8000, 16'h0000, 1, 1, 0, 0, 16'h8000, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 0;
    in_a = 16'h3F80; in_b = 16'h4000; in_sel_min = 0; in_alt = 0; in_lane_en = 1;
    in_valid = 1;
    @(negedge clk);
    in_a = 16'hC000; in_b = 16'h4100; in_sel_min = 1;
    chk("R9 stall in_ready", {16'h0, in_ready}, 17'h0);
    chk("R9 first held", {out_inv, out_res}, {1'b0, 16'h4000});
    @(negedge clk);
    chk("R9 still held", {out_inv, out_res}, {1'b0, 16'h4000});
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R9 second after release", {out_valid, out_res}, {1'b1, 16'hC000});
    @(negedge clk);
    chk("R9 drained", {16'h0, out_valid}, 17'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_numeric();
    t_zero_strict();
    t_zero_alt();
    t_nan_default();
    t_nan_prop();
    t_nan_alt();
    t_inactive();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule